// File: doc/BRIEF.md
# Four-Port Write Conflict Resolver

This block sits between four write requesters and a memory array that has four write ports. Each cycle it compares the addresses of all enabled write ports pairwise and, wherever two or more enabled ports aim at the same word, forwards the write enable of exactly one of them. The other ports in that group lose their enables. Writes to distinct addresses are forwarded untouched. As a result the array never sees two simultaneous writes to one word, which would leave that word undefined.

A mode input chooses the winner of a colliding group. In fixed mode the lowest port index wins. In rotating mode a one-hot token picks the favoured port. Arbitration applies only inside a colliding group, so writes that do not collide always go through in the same cycle. Addresses and data pass straight through. A collision flag and a mask of suppressed enables report every conflict, for example to a statistics counter. The path from inputs to outputs is combinational; the token register is the only state.

Top module: `wcr_conflict_resolver`

## Requirements
- R1: In any cycle with no two enabled ports on the same address, out_en equals wr_en.
- R2: out_addr equals wr_addr and out_data equals wr_data in every cycle, bit for bit. Port p occupies bits [p*W +: W] of each flattened bus.
- R3: No two asserted bits of out_en carry the same address in any cycle.
- R4: With rr_mode=0, the lowest-numbered port of each colliding group keeps its enable and the others in the group lose theirs.
- R5: With rr_mode=1, the port in each colliding group that wins is the first member found when searching upward from the token position, wrapping from port 3 to port 0. This is the token holder itself when the holder is in the group.
- R6: The token is one-hot and resets to port 0 under synchronous active-low rst_n. At a clock edge it moves from port p to port (p+1) mod 4 only when rr_mode=1 and the holder's out_en bit is 1. Otherwise it holds.
- R7: Whether the colliding ports carry equal or different data has no effect on which port wins.
- R8: Disjoint colliding groups in one cycle are resolved independently, each forwarding exactly one write.
- R9: collision is 1 exactly when at least one pair of enabled ports shares an address. loser_mask equals wr_en & ~out_en.
- R10: A port with wr_en=0 never asserts out_en, and its address takes part in no comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rr_mode | input | 1 | 1 selects rotating priority; 0 selects fixed priority by index |
| wr_en | input | 4 | Requested write enable per port |
| wr_addr | input | 4*ADDR_W | Write addresses, port p at [p*ADDR_W +: ADDR_W] |
| wr_data | input | 4*DATA_W | Write data, port p at [p*DATA_W +: DATA_W] |
| out_en | output | 4 | Filtered write enables to the array |
| out_addr | output | 4*ADDR_W | Forwarded addresses |
| out_data | output | 4*DATA_W | Forwarded data |
| collision | output | 1 | At least one address conflict this cycle |
| loser_mask | output | 4 | Enables suppressed this cycle |

## Verification
Two things can fall in the same cycle: a colliding group being resolved, and unrelated writes, or a second group, going through untouched. In rotating mode the token may also advance in that same cycle. The bench provokes all of this by drawing random addresses from only four values, so collisions and disjoint pairs are frequent, and by adding directed cases such as two pairs on two addresses and a token holder that sits outside the group. Each cycle it compares the enables, flag and mask against a bench model that tracks its own copy of the token.

// File: rtl/wcr_pkg.sv
// Shared constants for the write conflict resolver.
// Assumes a fixed port count of four (six pairwise comparators).
package wcr_pkg;
    localparam int NP = 4;
    localparam int IW = $clog2(NP);
    localparam int NPAIR = NP * (NP - 1) / 2;
endpackage

// File: rtl/wcr_addr_match.sv
// Pairwise address comparator.
// Produces a symmetric matrix in which match[i][j] is set when ports i and j
// are both enabled and carry equal addresses. The diagonal is zero.
module wcr_addr_match
    import wcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [NP-1:0]        en,
    input  logic [NP*ADDR_W-1:0] addr,
    output logic [NP-1:0][NP-1:0] match
);
    genvar gi, gj;
    generate
        for (gi = 0; gi < NP; gi++) begin : g_row
            for (gj = 0; gj < NP; gj++) begin : g_col
                if (gi == gj) begin : g_diag
                    assign match[gi][gj] = 1'b0;
                end else if (gi < gj) begin : g_cmp
                    // one comparator per unordered pair
                    assign match[gi][gj] = en[gi] && en[gj] &&
                        (addr[gi*ADDR_W +: ADDR_W] == addr[gj*ADDR_W +: ADDR_W]);
                end else begin : g_mirror
                    assign match[gi][gj] = match[gj][gi];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/wcr_rr_token.sv
// Rotating-priority token.
// A one-hot register naming the favoured port. It resets to port 0 and moves
// up one place only in rotating mode, after its holder has been forwarded a write.
module wcr_rr_token
    import wcr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rr_mode,
    input  logic [NP-1:0] granted,
    output logic [NP-1:0] token
);
    // advance the token when its holder wrote
    always_ff @(posedge clk) begin
        if (!rst_n)
            token <= NP'(1);
        else if (rr_mode && |(token & granted))
            token <= {token[NP-2:0], token[NP-1]};
    end

    // R6
    token_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(token) == 1);

    // R6
    token_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rr_mode && |(token & granted)) |=> $stable(token));
endmodule

// File: rtl/wcr_grant_select.sv
// Winner selection within colliding groups.
// A port keeps its enable unless a colliding port ranks above it. Fixed mode
// ranks by index. Rotating mode ranks by distance upward from the token,
// with wrap-around. Assumes the match matrix is symmetric and zero on the diagonal.
module wcr_grant_select
    import wcr_pkg::*;
(
    input  logic                  rr_mode,
    input  logic [NP-1:0]         en,
    input  logic [NP-1:0][NP-1:0] match,
    input  logic [NP-1:0]         token,
    output logic [NP-1:0]         grant
);
    logic [IW-1:0]         tok_idx;
    logic [NP-1:0][IW-1:0] rank;
    logic [NP-1:0][NP-1:0] beats;   // beats[j][i]: port j blocks port i

    // encode the one-hot token into an index
    always_comb begin
        tok_idx = '0;
        for (int k = 0; k < NP; k++)
            if (token[k]) tok_idx = IW'(k);
    end

    // rank of each port: fixed index or distance from the token
    always_comb begin
        for (int k = 0; k < NP; k++)
            rank[k] = rr_mode ? (IW'(k) - tok_idx) : IW'(k);
    end

    // find blockers and derive grants
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            for (int j = 0; j < NP; j++)
                beats[j][i] = match[i][j] && (rank[j] < rank[i]);
            grant[i] = en[i];
            for (int j = 0; j < NP; j++)
                if (beats[j][i]) grant[i] = 1'b0;
        end
    end
endmodule

// File: rtl/wcr_conflict_resolver.sv
// Four-port write conflict resolver (top).
// Filters the write enables so that at most one write per address reaches the
// array each cycle. Addresses and data pass straight through. The only state
// is the rotating token, reset synchronously by active-low rst_n.
module wcr_conflict_resolver
    import wcr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rr_mode,
    input  logic [3:0]            wr_en,
    input  logic [4*ADDR_W-1:0]   wr_addr,
    input  logic [4*DATA_W-1:0]   wr_data,
    output logic [3:0]            out_en,
    output logic [4*ADDR_W-1:0]   out_addr,
    output logic [4*DATA_W-1:0]   out_data,
    output logic                  collision,
    output logic [3:0]            loser_mask
);
    logic [NP-1:0][NP-1:0] match;
    logic [NP-1:0]         token;
    logic [NP-1:0]         grant;

    wcr_addr_match #(.ADDR_W(ADDR_W)) match_i (
        .en    (wr_en),
        .addr  (wr_addr),
        .match (match)
    );

    wcr_grant_select grant_i (
        .rr_mode (rr_mode),
        .en      (wr_en),
        .match   (match),
        .token   (token),
        .grant   (grant)
    );

    wcr_rr_token token_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rr_mode (rr_mode),
        .granted (grant),
        .token   (token)
    );

    // drive the array side and the conflict report
    always_comb begin
        out_en     = grant;
        out_addr   = wr_addr;
        out_data   = wr_data;
        collision  = |match;
        loser_mask = wr_en & ~grant;
    end

    // R3: no two forwarded writes share an address
    genvar gi, gj;
    generate
        for (gi = 0; gi < NP; gi++) begin : g_pa
            for (gj = gi + 1; gj < NP; gj++) begin : g_pb
                // R3
                unique_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !(out_en[gi] && out_en[gj] &&
                      out_addr[gi*ADDR_W +: ADDR_W] == out_addr[gj*ADDR_W +: ADDR_W]));
            end
        end
    endgenerate

    // R10
    no_spurious_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en & ~wr_en) == 4'b0);

    // R1
    clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !collision |-> out_en == wr_en);

    // R9
    loser_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> loser_mask != 4'b0);
endmodule

// File: tb/wcr_conflict_resolver_tb_top.sv
`timescale 1ns/1ps
module wcr_conflict_resolver_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rr_mode = 1'b0;
    logic [3:0]      wr_en = '0;
    logic [4*AW-1:0] wr_addr = '0;
    logic [4*DW-1:0] wr_data = '0;
    logic [3:0]      out_en;
    logic [4*AW-1:0] out_addr;
    logic [4*DW-1:0] out_data;
    logic            collision;
    logic [3:0]      loser_mask;

    int n_cmp = 0;
    int n_bad = 0;
    int mtok  = 0;   // bench copy of the token position

    always #2 clk = ~clk;   // 250 MHz

    wcr_conflict_resolver #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .out_en(out_en),
        .out_addr(out_addr), .out_data(out_data), .collision(collision),
        .loser_mask(loser_mask));

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_en(logic [3:0] en, logic [4*AW-1:0] a,
                                          bit rr, int tok);
        logic [3:0] r = en;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                if (i != j && en[i] && en[j] && a[i*AW +: AW] == a[j*AW +: AW]) begin
                    if (rr) begin
                        if (((j - tok + 4) % 4) < ((i - tok + 4) % 4)) r[i] = 1'b0;
                    end else if (j < i) r[i] = 1'b0;
                end
        return r;
    endfunction

    function automatic bit exp_col(logic [3:0] en, logic [4*AW-1:0] a);
        bit c = 0;
        for (int i = 0; i < 4; i++)
            for (int j = i + 1; j < 4; j++)
                if (en[i] && en[j] && a[i*AW +: AW] == a[j*AW +: AW]) c = 1;
        return c;
    endfunction

    // drive at negedge, check mid-phase, then update the model token
    task automatic step(bit rr, logic [3:0] en, logic [4*AW-1:0] a,
                        logic [4*DW-1:0] d, string tag);
        logic [3:0] e;
        @(negedge clk);
        rr_mode = rr; wr_en = en; wr_addr = a; wr_data = d;
        #1;
        e = exp_en(en, a, rr, mtok);
        chk({tag, " out_en"}, 64'(out_en), 64'(e));
        chk("R9 collision", 64'(collision), 64'(exp_col(en, a)));
        chk("R9 loser_mask", 64'(loser_mask), 64'(en & ~e));
        chk("R2 addr", 64'(out_addr), 64'(a));
        chk("R2 data", 64'(out_data), 64'(d));
        if (rr && e[mtok]) mtok = (mtok + 1) % 4;
    endtask

    function automatic logic [4*AW-1:0] pk(int a0, int a1, int a2, int a3);
        return {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
    endfunction

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] e0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        e0 = out_en;
        chk("R10 reset out_en idle", 64'(e0), 64'(0));
        @(negedge clk) rst_n = 1'b1;
        mtok = 0;
        // R6: right after reset, all collide in rotating mode -> port 0 wins
        step(1, 4'hF, pk(5,5,5,5), 64'h1111_2222_3333_4444, "R6 reset token");
        // R5: token at 1, holder not in group {2,3} -> port 2; token holds
        step(1, 4'b1100, pk(0,0,9,9), '0, "R5 holder absent");
        step(1, 4'b1011, pk(7,7,0,7), '0, "R5 holder wins");
        // token now at 2: group {0,1,3} with wrap -> port 3
        step(1, 4'b1011, pk(4,4,0,4), '0, "R5 wrap");
        // R4 fixed priority
        step(0, 4'b1110, pk(0,3,3,3), '0, "R4 lowest wins");
        // R7: equal data vs different data, same winner
        step(0, 4'b0110, pk(0,8,8,0), 64'hAAAA_BBBB_BBBB_AAAA, "R7 equal data");
        step(0, 4'b0110, pk(0,8,8,0), 64'hAAAA_CCCC_BBBB_AAAA, "R7 diff data");
        // R8 disjoint groups in both modes
        step(0, 4'hF, pk(1,1,2,2), '0, "R8 two groups fixed");
        step(1, 4'hF, pk(1,1,2,2), '0, "R8 two groups rr");
        // R1 distinct addresses
        step(0, 4'hF, pk(1,2,3,4), '0, "R1 distinct");
        // R10 disabled port with matching address is ignored
        step(0, 4'b0010, pk(6,6,6,6), '0, "R10 disabled ignored");
        // R6 token holds in fixed mode, then rr collision checks position
        step(0, 4'hF, pk(1,2,3,4), '0, "R6 fixed hold");
        step(1, 4'hF, pk(3,3,3,3), '0, "R6 position");
        // random mix with narrow address range
        for (int n = 0; n < 3000; n++) begin
            logic [4*AW-1:0] a;
            for (int p = 0; p < 4; p++) a[p*AW +: AW] = AW'($urandom % 4);
            step(1'($urandom % 2), 4'($urandom), a,
                 {$urandom, $urandom}, "R4 R5 random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule